// File: doc/BRIEF.md
# Mailbox Request/Response Transaction Engine

This block acts as the requester for one complete exchange over a data-object mailbox that sits behind a simple dword register bus. The mailbox has four registers: control, status, write-mailbox and read-mailbox. A client pulses `start` and supplies four things:
- a 16-bit vendor ID and an 8-bit object type;
- a request payload, read from a small client-held buffer through `pl_idx`/`pl_data`;
- the capacity of its response buffer.

The engine then does the following:
- It checks that the mailbox is free.
- It pushes a two-dword header and the payload, and sets the go bit.
- It polls the status register at a fixed interval until a response is ready, or gives up after a timeout.
- It reads the response one dword at a time, acknowledging each read by writing zero to the read-mailbox register. It checks the header, stores as many payload dwords as fit in the client buffer and drains the rest.
- It ends with a done pulse that carries an error code and a byte count.

Any failure triggers an abort sequence. If the mailbox does not recover from the abort within the timeout, the engine enters a dead state. It leaves the dead state only on reset.

Register offsets on `bus_addr`: 0 control, 1 status, 2 write-mailbox, 3 read-mailbox.
- Status bits: bit 0 busy, bit 2 error, bit 31 data-object-ready.
- Control bits: bit 0 abort, bit 31 go.
- Error codes on `err_code`: 0 success, 1 busy, 2 I/O error.
- The timeout is `TIMEOUT_CYCLES` clock cycles. The poll interval is `TIMEOUT_CYCLES/128` cycles.

Top module: `mbox_xfer_engine`

## Requirements
- R1: The first bus operation after `start` is a status read. If busy (bit 0) is set, the exchange fails with code 1. Otherwise, if error (bit 2) is set, it fails with code 2.
- R2: The engine then writes to offset 2, in this order: header dword one, with the vendor ID in bits 15:0, the type in bits 23:16 and zero above; header dword two, equal to the payload dword count plus 2; then each payload dword from index 0 upward. It then writes 32'h8000_0000 (go) to offset 0.
- R3: A status read follows the go write. Later polls are at least the poll interval apart. Error set on a poll fails the exchange with code 2. If ready (bit 31) has not been seen once `TIMEOUT_CYCLES` cycles have passed since the go write, the exchange fails with code 2.
- R4: If the vendor ID or type in the first response dword differs from the request, the exchange fails with code 2. That dword is not acknowledged.
- R5: Every read of offset 3 that is accepted is followed by a write of 32'h0 to offset 3, before any other read of offset 3. This includes both header dwords.
- R6: Bits 21:0 of the second response dword give the total object length in dwords. A length below 2 or above 1048576 fails the exchange with code 2.
- R7: The engine presents the first min(length-2, capacity) payload dwords on `rsp_we`/`rsp_idx`/`rsp_data`, with indices from 0 upward. The remaining payload dwords are read and acknowledged but not presented.
- R8: Between reading the last stored dword and acknowledging it, the engine reads status. If ready is clear, the exchange fails with code 2.
- R9: After the last acknowledgement, the engine reads status once more. If error is set, the exchange fails with code 2. Otherwise `done` pulses with code 0 and `rsp_bytes` equal to 4 times the stored count.
- R10: On every failure the engine writes 32'h1 (abort) to offset 0. It then reads status once per poll interval. When both error and busy are clear, `done` reports the original code. If `TIMEOUT_CYCLES` pass without that, `dead` is set and `done` reports the original code.
- R11: While `dead` is set, `start` produces `done` with code 2 on the next cycle and no bus traffic. `dead` holds until reset.
- R12: A bus request keeps its address, direction and data unchanged until `bus_ready`. Requests appear only while `busy` is high.
- R13: After reset, `busy`, `done`, `dead`, `bus_valid` and `rsp_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (taken when idle) |
| req_vid | input | 16 | Request vendor ID |
| req_type | input | 8 | Request object type |
| req_dwords | input | PL_AW+1 | Request payload dword count |
| rsp_cap | input | RSP_AW+1 | Response buffer capacity in dwords |
| pl_idx | output | PL_AW | Index into the client payload buffer |
| pl_data | input | 32 | Payload dword at `pl_idx` |
| rsp_we | output | 1 | Store strobe for a response dword |
| rsp_idx | output | RSP_AW | Response buffer index |
| rsp_data | output | 32 | Response dword |
| bus_valid | output | 1 | Register bus request valid |
| bus_write | output | 1 | Request is a write |
| bus_addr | output | 2 | Register offset |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Request accepted |
| bus_rvalid | input | 1 | Read data valid |
| bus_rdata | input | 32 | Read data |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result code, valid with `done` |
| rsp_bytes | output | RSP_AW+3 | Stored byte count, valid with `done` |
| dead | output | 1 | Mailbox declared unusable |

## Verification
Most results of this block are orderings of register-bus transactions rather than values at a fixed cycle. The bench's mailbox model therefore logs every accepted transaction on the clock it is accepted. It compares the log with the sequence derived from the requirements for each scenario.

Results that are due at a fixed time are sampled on the falling edge after the registering edge:
- The completion pulse comes one cycle after the closing status read data arrives, or one cycle after `start` when dead.
- Each store strobe comes one cycle after its read data.

The timeout paths are checked by bounding cycle distances: at least `TIMEOUT_CYCLES` after the go or abort write, and at most three poll intervals beyond it. Polls are checked to be spaced by at least the poll interval.

// File: rtl/mbox_xfer_engine.sv
module mbox_xfer_engine #(
  parameter int PL_DEPTH       = 8,
  parameter int RSP_DEPTH      = 8,
  parameter int TIMEOUT_CYCLES = 250_000_000,
  parameter int MAX_OBJ_DW     = 1 << 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [15:0]                   req_vid,
  input  logic [7:0]                    req_type,
  input  logic [$clog2(PL_DEPTH):0]     req_dwords,
  input  logic [$clog2(RSP_DEPTH):0]    rsp_cap,
  output logic [$clog2(PL_DEPTH)-1:0]   pl_idx,
  input  logic [31:0]                   pl_data,
  output logic                          rsp_we,
  output logic [$clog2(RSP_DEPTH)-1:0]  rsp_idx,
  output logic [31:0]                   rsp_data,
  output logic                          bus_valid,
  output logic                          bus_write,
  output logic [1:0]                    bus_addr,
  output logic [31:0]                   bus_wdata,
  input  logic                          bus_ready,
  input  logic                          bus_rvalid,
  input  logic [31:0]                   bus_rdata,
  output logic                          busy,
  output logic                          done,
  output logic [1:0]                    err_code,
  output logic [$clog2(RSP_DEPTH)+2:0]  rsp_bytes,
  output logic                          dead
);
  localparam int PL_AW    = $clog2(PL_DEPTH);
  localparam int RSP_AW   = $clog2(RSP_DEPTH);
  localparam int POLL_GAP = (TIMEOUT_CYCLES / 128 > 0) ? TIMEOUT_CYCLES / 128 : 1;
  localparam int TW       = $clog2(TIMEOUT_CYCLES + 1) + 1;
  localparam int GW       = $clog2(POLL_GAP + 1);
  localparam int LW       = 22;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_WMB = 2'd2, A_RMB = 2'd3;
  localparam logic [1:0] E_OK = 2'd0, E_BUSY = 2'd1, E_IO = 2'd2;

  typedef enum logic [4:0] {
    S_IDLE, S_CHK, S_CHKW, S_SEND, S_GO, S_POLL, S_POLLW, S_WAIT,
    S_RX, S_RXW, S_ACK, S_RDY, S_RDYW, S_FIN, S_FINW,
    S_ABW, S_ABGAP, S_ABR, S_ABRW
  } st_t;

  st_t               state;
  logic [15:0]       vid_q;
  logic [7:0]        type_q;
  logic [PL_AW:0]    ndw_q;
  logic [RSP_AW:0]   cap_q;
  logic [LW-1:0]     idx, len_q;
  logic [TW-1:0]     tmr;
  logic [GW-1:0]     gap;
  logic [1:0]        pend;

  logic              acc, timed_out, tmr_clr;
  logic              st_busy, st_err, st_rdy;
  logic [LW-1:0]     pidx, paylen, capx, nstore, rlen;

  assign acc       = bus_valid && bus_ready;
  assign timed_out = tmr >= TW'(TIMEOUT_CYCLES);
  assign tmr_clr   = acc && (state == S_GO || state == S_ABW);
  assign st_busy   = bus_rdata[0];
  assign st_err    = bus_rdata[2];
  assign st_rdy    = bus_rdata[31];
  assign rlen      = bus_rdata[LW-1:0];
  assign pidx      = idx - LW'(2);
  assign paylen    = len_q - LW'(2);
  assign capx      = LW'(cap_q);
  assign nstore    = (paylen < capx) ? paylen : capx;
  assign pl_idx    = pidx[PL_AW-1:0];
  assign busy      = state != S_IDLE;

  assign bus_valid = state inside {S_CHK, S_SEND, S_GO, S_POLL, S_RX, S_ACK,
                                   S_RDY, S_FIN, S_ABW, S_ABR};
  assign bus_write = state inside {S_SEND, S_GO, S_ACK, S_ABW};

  always_comb begin
    bus_addr  = A_STAT;
    bus_wdata = 32'h0;
    case (state)
      S_SEND: begin
        bus_addr = A_WMB;
        if (idx == '0)           bus_wdata = {8'h00, type_q, vid_q};
        else if (idx == LW'(1))  bus_wdata = 32'(ndw_q) + 32'd2;
        else                     bus_wdata = pl_data;
      end
      S_GO:        begin bus_addr = A_CTRL; bus_wdata = 32'h8000_0000; end
      S_ABW:       begin bus_addr = A_CTRL; bus_wdata = 32'h0000_0001; end
      S_RX, S_ACK: bus_addr = A_RMB;
      default:     bus_addr = A_STAT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      vid_q <= '0; type_q <= '0; ndw_q <= '0; cap_q <= '0;
      idx <= '0; len_q <= '0; tmr <= '0; gap <= '0; pend <= E_OK;
      done <= 1'b0; err_code <= E_OK; rsp_bytes <= '0; dead <= 1'b0;
      rsp_we <= 1'b0; rsp_idx <= '0; rsp_data <= '0;
    end else begin
      done   <= 1'b0;
      rsp_we <= 1'b0;
      if (tmr_clr)         tmr <= '0;
      else if (!timed_out) tmr <= tmr + TW'(1);

      case (state)
        S_IDLE: if (start) begin
          if (dead) begin
            done <= 1'b1; err_code <= E_IO; rsp_bytes <= '0;
          end else begin
            vid_q <= req_vid; type_q <= req_type;
            ndw_q <= req_dwords; cap_q <= rsp_cap;
            state <= S_CHK;
          end
        end
        S_CHK:  if (acc) state <= S_CHKW;
        S_CHKW: if (bus_rvalid) begin
          if (st_busy)     begin pend <= E_BUSY; state <= S_ABW; end
          else if (st_err) begin pend <= E_IO;   state <= S_ABW; end
          else             begin idx <= '0;      state <= S_SEND; end
        end
        S_SEND: if (acc) begin
          if (idx == LW'(ndw_q) + LW'(1)) state <= S_GO;
          else idx <= idx + LW'(1);
        end
        S_GO:   if (acc) state <= S_POLL;
        S_POLL: if (acc) state <= S_POLLW;
        S_POLLW: if (bus_rvalid) begin
          if (st_err)         begin pend <= E_IO; state <= S_ABW; end
          else if (st_rdy)    begin idx <= '0;    state <= S_RX; end
          else if (timed_out) begin pend <= E_IO; state <= S_ABW; end
          else begin gap <= GW'(POLL_GAP - 1); state <= S_WAIT; end
        end
        S_WAIT: if (gap == '0) state <= S_POLL; else gap <= gap - GW'(1);
        S_RX:   if (acc) state <= S_RXW;
        S_RXW: if (bus_rvalid) begin
          if (idx == '0) begin
            if (bus_rdata[15:0] != vid_q || bus_rdata[23:16] != type_q) begin
              pend <= E_IO; state <= S_ABW;
            end else state <= S_ACK;
          end else if (idx == LW'(1)) begin
            if (rlen < LW'(2) || rlen > LW'(MAX_OBJ_DW)) begin
              pend <= E_IO; state <= S_ABW;
            end else begin
              len_q <= rlen; state <= S_ACK;
            end
          end else if (pidx < nstore) begin
            rsp_we   <= 1'b1;
            rsp_idx  <= pidx[RSP_AW-1:0];
            rsp_data <= bus_rdata;
            state    <= (pidx == nstore - LW'(1)) ? S_RDY : S_ACK;
          end else state <= S_ACK;
        end
        S_ACK: if (acc) begin
          if (idx != '0 && idx + LW'(1) == len_q) state <= S_FIN;
          else begin idx <= idx + LW'(1); state <= S_RX; end
        end
        S_RDY:  if (acc) state <= S_RDYW;
        S_RDYW: if (bus_rvalid) begin
          if (st_rdy) state <= S_ACK;
          else begin pend <= E_IO; state <= S_ABW; end
        end
        S_FIN:  if (acc) state <= S_FINW;
        S_FINW: if (bus_rvalid) begin
          if (st_err) begin pend <= E_IO; state <= S_ABW; end
          else begin
            done <= 1'b1; err_code <= E_OK;
            rsp_bytes <= {nstore[RSP_AW:0], 2'b00};
            state <= S_IDLE;
          end
        end
        S_ABW: if (acc) begin gap <= GW'(POLL_GAP - 1); state <= S_ABGAP; end
        S_ABGAP: if (gap == '0) state <= S_ABR; else gap <= gap - GW'(1);
        S_ABR:  if (acc) state <= S_ABRW;
        S_ABRW: if (bus_rvalid) begin
          if (!st_err && !st_busy) begin
            done <= 1'b1; err_code <= pend; rsp_bytes <= '0; state <= S_IDLE;
          end else if (timed_out) begin
            dead <= 1'b1;
            done <= 1'b1; err_code <= pend; rsp_bytes <= '0; state <= S_IDLE;
          end else begin
            gap <= GW'(POLL_GAP - 1); state <= S_ABGAP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_xfer_engine_chk.sv
module mbox_xfer_engine_chk #(
  parameter int BW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [1:0]    err_code,
  input logic [BW-1:0] rsp_bytes,
  input logic          dead,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_write,
  input logic [1:0]    bus_addr,
  input logic [31:0]   bus_wdata
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata));

  assert_req_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> busy);

  assert_dead_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dead |=> dead);

  assert_dead_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dead && !busy |-> !bus_valid);

  assert_dead_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dead && !busy && start |=> done && err_code == 2'd2);

  assert_dead_on_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dead) |-> done && err_code != 2'd0);

  assert_bytes_whole_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_code == 2'd0 |-> rsp_bytes[1:0] == 2'b00);
endmodule

bind mbox_xfer_engine mbox_xfer_engine_chk #(.BW(RSP_AW + 3)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_code(err_code), .rsp_bytes(rsp_bytes), .dead(dead),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/test_mbox_xfer_engine.sv
`timescale 1ns/1ps
module test_mbox_xfer_engine;
  localparam int TO = 1280;
  localparam int G  = TO / 128;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start;
  logic [15:0] req_vid;
  logic [7:0]  req_type;
  logic [3:0]  req_dwords, rsp_cap;
  logic [2:0]  pl_idx, rsp_idx;
  logic [31:0] pl_data, rsp_data, bus_wdata, bus_rdata;
  logic rsp_we, bus_valid, bus_write, bus_ready, bus_rvalid, busy, done, dead;
  logic [1:0]  bus_addr, err_code;
  logic [5:0]  rsp_bytes;

  logic [31:0] plbuf [8];
  assign pl_data = plbuf[pl_idx];

  mbox_xfer_engine #(.PL_DEPTH(8), .RSP_DEPTH(8), .TIMEOUT_CYCLES(TO)) i_mbox_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .req_vid(req_vid), .req_type(req_type),
    .req_dwords(req_dwords), .rsp_cap(rsp_cap), .pl_idx(pl_idx), .pl_data(pl_data),
    .rsp_we(rsp_we), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .err_code(err_code), .rsp_bytes(rsp_bytes), .dead(dead));

  int nchk = 0, nerr = 0, cyc = 0;
  logic s_busy, s_err, rsp_loaded, abort_ok, stall_en, err_on_go, rdy_tog = 1'b0;
  int drop_at, err_on_ack, rptr, rmb_reads, acks;
  logic [31:0] rq[$];
  logic [34:0] lg[$], ex[$];
  int lg_cyc[$];
  logic [31:0] got [8];

  always @(negedge clk) rdy_tog <= ~rdy_tog;
  assign bus_ready = !stall_en || rdy_tog;

  function automatic logic [31:0] stat_word();
    logic rdy;
    rdy = rsp_loaded && !(drop_at >= 0 && rmb_reads >= drop_at);
    return {rdy, 28'h0, s_err, 1'b0, s_busy};
  endfunction

  always @(posedge clk) begin
    cyc++;
    bus_rvalid <= 1'b0;
    if (rsp_we) got[rsp_idx] <= rsp_data;
    if (bus_valid && bus_ready) begin
      lg.push_back({bus_write, bus_addr, bus_write ? bus_wdata : 32'h0});
      lg_cyc.push_back(cyc);
      if (!bus_write) begin
        bus_rvalid <= 1'b1;
        if (bus_addr == 2'd1) bus_rdata <= stat_word();
        else if (bus_addr == 2'd3) begin
          bus_rdata <= (rptr < rq.size()) ? rq[rptr] : 32'h0;
          rmb_reads++;
        end else bus_rdata <= 32'h0;
      end else if (bus_addr == 2'd0) begin
        if (bus_wdata[0] && abort_ok) begin s_busy = 1'b0; s_err = 1'b0; end
        if (bus_wdata[31] && err_on_go) s_err = 1'b1;
      end else if (bus_addr == 2'd3) begin
        rptr++; acks++;
        if (acks == err_on_ack) s_err = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic env_clear();
    s_busy = 0; s_err = 0; rsp_loaded = 0; abort_ok = 1; stall_en = 0; err_on_go = 0;
    drop_at = -1; err_on_ack = -1; rptr = 0; rmb_reads = 0; acks = 0;
    rq.delete(); lg.delete(); lg_cyc.delete(); ex.delete();
    for (int i = 0; i < 8; i++) begin got[i] = 32'h0; plbuf[i] = 32'hA500_0000 + 32'(i * 7); end
  endtask

  task automatic e_r(input logic [1:0] a); ex.push_back({1'b0, a, 32'h0}); endtask
  task automatic e_w(input logic [1:0] a, input logic [31:0] d); ex.push_back({1'b1, a, d}); endtask

  task automatic load_rsp(input logic [15:0] v, input logic [7:0] t, input int len, input int npay);
    rq.push_back({8'h00, t, v});
    rq.push_back(32'(len));
    for (int i = 0; i < npay; i++) rq.push_back(32'hC0DE_0000 + 32'(i));
    rsp_loaded = 1;
  endtask

  task automatic exp_front(input logic [15:0] v, input logic [7:0] t, input int n);
    e_r(2'd1);
    e_w(2'd2, {8'h00, t, v});
    e_w(2'd2, 32'(n + 2));
    for (int i = 0; i < n; i++) e_w(2'd2, plbuf[i]);
    e_w(2'd0, 32'h8000_0000);
    e_r(2'd1);
  endtask

  task automatic exp_rx(input int len, input int cap);
    int nst;
    nst = (len - 2 < cap) ? len - 2 : cap;
    e_r(2'd3); e_w(2'd3, 0); e_r(2'd3); e_w(2'd3, 0);
    for (int i = 0; i < len - 2; i++) begin
      e_r(2'd3);
      if (i == nst - 1) e_r(2'd1);
      e_w(2'd3, 0);
    end
    e_r(2'd1);
  endtask

  task automatic exp_abort(); e_w(2'd0, 32'h1); e_r(2'd1); endtask

  int waited;
  task automatic run(input logic [15:0] v, input logic [7:0] t, input int n, input int cap);
    @(negedge clk);
    req_vid = v; req_type = t; req_dwords = 4'(n); rsp_cap = 4'(cap); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 20000) begin @(negedge clk); waited++; end
    chk(done == 1'b1, "R9", "completion seen", done, 1);
  endtask

  task automatic cmp_seq(input string req);
    chk(lg.size() == ex.size(), req, "transaction count", lg.size(), ex.size());
    for (int i = 0; i < ex.size() && i < lg.size(); i++)
      chk(lg[i] == ex[i], req, $sformatf("transaction %0d", i), lg[i], ex[i]);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; req_vid = 0; req_type = 0; req_dwords = 0; rsp_cap = 0;
    bus_rdata = 0; bus_rvalid = 0;
    env_clear();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !dead && !bus_valid && !rsp_we, "R13", "reset outputs",
        {busy, done, dead, bus_valid, rsp_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_valid, "R13", "idle after reset", {busy, bus_valid}, 0);

    // R2 R5 R7 R8 R9: nominal exchange
    env_clear();
    load_rsp(16'h1AB4, 8'h05, 5, 3);
    exp_front(16'h1AB4, 8'h05, 3); exp_rx(5, 4);
    run(16'h1AB4, 8'h05, 3, 4);
    chk(err_code == 0, "R9", "nominal code", err_code, 0);
    chk(rsp_bytes == 12, "R9", "nominal bytes", rsp_bytes, 12);
    for (int i = 0; i < 3; i++)
      chk(got[i] == 32'hC0DE_0000 + 32'(i), "R7", "stored dword", got[i], 32'hC0DE_0000 + 32'(i));
    cmp_seq("R2_R5_R8");

    // R7 R12: excess drained, bus stalls every other cycle
    env_clear();
    stall_en = 1;
    load_rsp(16'h0F00, 8'h21, 7, 5);
    exp_front(16'h0F00, 8'h21, 2); exp_rx(7, 2);
    run(16'h0F00, 8'h21, 2, 2);
    chk(err_code == 0 && rsp_bytes == 8, "R7", "capped bytes", rsp_bytes, 8);
    chk(got[2] == 32'h0, "R7", "excess not stored", got[2], 0);
    cmp_seq("R7_R12");

    // R2 R9: empty request, empty response
    env_clear();
    load_rsp(16'h0001, 8'h00, 2, 0);
    exp_front(16'h0001, 8'h00, 0); exp_rx(2, 3);
    run(16'h0001, 8'h00, 0, 3);
    chk(err_code == 0 && rsp_bytes == 0, "R9", "empty bytes", rsp_bytes, 0);
    cmp_seq("R2_R9");

    // R1 busy, R10 abort recovery
    env_clear();
    s_busy = 1;
    e_r(2'd1); exp_abort();
    run(16'h1234, 8'h01, 1, 1);
    chk(err_code == 1, "R1", "busy code", err_code, 1);
    chk(!dead, "R10", "no dead after good abort", dead, 0);
    cmp_seq("R1_R10");

    // R1 error bit
    env_clear();
    s_err = 1;
    e_r(2'd1); exp_abort();
    run(16'h1234, 8'h01, 1, 1);
    chk(err_code == 2, "R1", "error code", err_code, 2);
    cmp_seq("R1");

    // R4 header mismatch
    env_clear();
    load_rsp(16'h1AB4, 8'h06, 5, 3);
    exp_front(16'h1AB4, 8'h05, 1); e_r(2'd3); exp_abort();
    run(16'h1AB4, 8'h05, 1, 4);
    chk(err_code == 2, "R4", "mismatch code", err_code, 2);
    cmp_seq("R4");

    // R6 short and long lengths
    env_clear();
    load_rsp(16'h00AA, 8'h02, 1, 0);
    exp_front(16'h00AA, 8'h02, 1);
    e_r(2'd3); e_w(2'd3, 0); e_r(2'd3); exp_abort();
    run(16'h00AA, 8'h02, 1, 4);
    chk(err_code == 2, "R6", "length 1 code", err_code, 2);
    cmp_seq("R6");
    env_clear();
    load_rsp(16'h00AA, 8'h02, 32'h100001, 0);
    exp_front(16'h00AA, 8'h02, 1);
    e_r(2'd3); e_w(2'd3, 0); e_r(2'd3); exp_abort();
    run(16'h00AA, 8'h02, 1, 4);
    chk(err_code == 2, "R6", "oversize code", err_code, 2);
    cmp_seq("R6");

    // R8 ready lost before last acknowledge
    env_clear();
    load_rsp(16'h0B0B, 8'h03, 4, 2);
    drop_at = 4;
    exp_front(16'h0B0B, 8'h03, 1);
    e_r(2'd3); e_w(2'd3, 0); e_r(2'd3); e_w(2'd3, 0);
    e_r(2'd3); e_w(2'd3, 0); e_r(2'd3); e_r(2'd1); exp_abort();
    run(16'h0B0B, 8'h03, 1, 4);
    chk(err_code == 2, "R8", "ready lost code", err_code, 2);
    cmp_seq("R8");

    // R3 error bit seen while polling
    env_clear();
    load_rsp(16'h0C0C, 8'h04, 3, 1);
    err_on_go = 1;
    exp_front(16'h0C0C, 8'h04, 2); exp_abort();
    run(16'h0C0C, 8'h04, 2, 2);
    chk(err_code == 2, "R3", "poll error code", err_code, 2);
    cmp_seq("R3");

    // R9 error appearing after drain
    env_clear();
    load_rsp(16'h0D0D, 8'h07, 4, 2);
    err_on_ack = 4;
    exp_front(16'h0D0D, 8'h07, 1); exp_rx(4, 4); exp_abort();
    run(16'h0D0D, 8'h07, 1, 4);
    chk(err_code == 2, "R9", "final error code", err_code, 2);
    cmp_seq("R9");

    // R3 poll timeout
    env_clear();
    run(16'h0E0E, 8'h08, 0, 1);
    chk(err_code == 2 && !dead, "R3", "timeout code", err_code, 2);
    begin
      int go_c, ab_c, prev;
      go_c = -1; ab_c = -1; prev = -1;
      for (int i = 0; i < lg.size(); i++) begin
        if (lg[i] == {1'b1, 2'd0, 32'h8000_0000}) go_c = lg_cyc[i];
        else if (lg[i] == {1'b1, 2'd0, 32'h1} && ab_c < 0) ab_c = lg_cyc[i];
        else if (go_c >= 0 && ab_c < 0 && lg[i] == {1'b0, 2'd1, 32'h0}) begin
          if (prev >= 0) chk(lg_cyc[i] - prev >= G, "R3", "poll spacing", lg_cyc[i] - prev, G);
          prev = lg_cyc[i];
        end
      end
      chk(go_c >= 0 && ab_c - go_c >= TO, "R3", "abort not before timeout", ab_c - go_c, TO);
      chk(ab_c - go_c <= TO + 3 * G, "R3", "abort soon after timeout", ab_c - go_c, TO + 3 * G);
    end

    // R10 abort failure -> dead; R11 rejection
    env_clear();
    s_busy = 1; abort_ok = 0;
    run(16'h0F0F, 8'h09, 0, 1);
    chk(dead == 1'b1, "R10", "dead set", dead, 1);
    chk(err_code == 1, "R10", "original code kept", err_code, 1);
    chk(lg.size() > 2 && lg[1] == {1'b1, 2'd0, 32'h1}, "R10", "abort write", lg[1], {1'b1, 2'd0, 32'h1});
    chk(lg_cyc[lg_cyc.size() - 1] - lg_cyc[1] >= TO, "R10", "abort polling window",
        lg_cyc[lg_cyc.size() - 1] - lg_cyc[1], TO);
    begin
      int n0;
      n0 = lg.size();
      run(16'h0F0F, 8'h09, 0, 1);
      chk(err_code == 2, "R11", "dead reject code", err_code, 2);
      chk(waited == 0, "R11", "reject next cycle", waited, 0);
      chk(lg.size() == n0, "R11", "no bus traffic when dead", lg.size(), n0);
      repeat (5) @(negedge clk);
      chk(dead == 1'b1 && !busy, "R11", "dead held", dead, 1);
    end
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dead == 1'b0, "R13", "dead cleared by reset", dead, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule